// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

This block is a watchdog that software must service by writing two fixed key bytes, in order, to two feed registers. An 8-bit down counter is reloaded from a limit register on each good feed. The counter steps down once per prescaler period. The prescaler runs either from a divided system clock or from a separate slow watchdog oscillator, which is brought into the system clock domain through a two-flop synchronizer. When the counter underflows while the watchdog is running, the block drives a reset pulse of fixed length and raises a sticky timeout flag.

Writes to the control register do not act at once. They are held in a shadow copy and reach the prescaler and counter only when the next bus access is a correct two-byte feed. A wrong key, a second key with no first key before it, or a control write whose very next write is not the first key, is treated as tampering and causes a reset pulse. Every reset event, whatever its cause, reloads the counter, clears the prescaler, drops any pending control value and returns the feed checker to idle.

Top module: `wdt_feed_top`

## Requirements
- R1: After rst_ni is released, wdt_rst_o is 0, wdtof_o is 0 and count_o is 0xFF. A write to the limit register does not change count_o until the next feed.
- R2: A write of 0xA5 to address 2, followed by a write of 0x5A to address 3, is a valid feed. It loads count_o from the limit register on the edge that takes the second key, and it restarts the prescaler. Between reloads, count_o changes only by stepping down by one.
- R3: A write to address 2 with any value other than 0xA5 starts a reset pulse. wdt_rst_o goes high after that edge and stays high for exactly RST_CYCLES (default 4) cycles.
- R4: A write to address 3 that does not directly follow a valid first key causes a reset pulse. So does any write other than 0x5A to address 3 that comes directly after a valid first key.
- R5: After a write to the control register at address 0, the next bus write must be 0xA5 to address 2. Any other write causes a reset pulse.
- R6: A control value takes effect only when the feed that follows it completes. If that feed fails, the value is discarded and the previous settings stay in force.
- R7: When the counter steps below zero while the run bit is set, a reset pulse starts, wdtof_o is set and count_o is reloaded from the limit register. Every reset pulse also sets wdtof_o.
- R8: While the run bit (control bit 2) is 0, the prescaler and counter hold their values and no timeout occurs.
- R9: With control bit 0 cleared, the counter steps once every 2^(P+10) system clock cycles, where P is control bits 7:5. A feed followed by limit L therefore times out after (L+1)*2^(P+10) cycles.
- R10: With control bit 0 set, the counter steps once every 2^(P+5) rising edges of wdclk_i.
- R11: wdtof_o is cleared only when a control value whose bit 1 is 0 is committed by a valid feed. Committing a value whose bit 1 is 1, or writing the limit register, leaves the flag set.
- R12: The address map is: 0 control, 1 limit, 2 first key, 3 second key. The control layout from bit 7 down is: prescaler select (3 bits), two unused bits, run, timeout flag, clock select. The reset value of the control register is 0xE5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdclk_i | input | 1 | Watchdog oscillator clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| wdtof_o | output | 1 | Sticky timeout flag |
| count_o | output | 8 | Current down-counter value |

## Verification
The checker looks at every cycle for the feed-protocol rules. A wrong first key, or any non-key write after a control write, must be followed by a reset pulse. The pulse must never last longer than its fixed length, a rising pulse must always carry the timeout flag, the flag may fall only right after a correct second key, and the counter may only step down or reload. What the per-cycle rules cannot show is left to the bench scenarios: the timeout latency for each clock source and prescaler setting, holding while stopped, and discarding a shadowed control value after a failed feed.

// File: rtl/wdt_feed_pkg.sv
package wdt_feed_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_LIMIT = 2'd1;
  localparam logic [ADDR_W-1:0] REG_KEY1  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_KEY2  = 2'd3;

  localparam logic [DATA_W-1:0] FEED_KEY1 = 8'hA5;
  localparam logic [DATA_W-1:0] FEED_KEY2 = 8'h5A;

  typedef struct packed {
    logic [2:0] pre;
    logic [1:0] rsvd;
    logic       run;
    logic       tof;
    logic       clk_sel;
  } wdt_ctrl_t;

  typedef enum logic [1:0] {
    FS_IDLE      = 2'd0,
    FS_CTRL_WAIT = 2'd1,
    FS_KEY1_OK   = 2'd2
  } feed_state_e;
endpackage

// File: rtl/wdt_feed_fsm.sv
module wdt_feed_fsm
  import wdt_feed_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flush_i,
  output logic              feed_ok_o,
  output logic              feed_err_o,
  output logic              ctrl_wait_o
);
  feed_state_e state_q, state_d;
  logic key1_hit, key2_hit;

  assign key1_hit = (wr_addr_i == REG_KEY1) && (wr_data_i == FEED_KEY1);
  assign key2_hit = (wr_addr_i == REG_KEY2) && (wr_data_i == FEED_KEY2);

  always_comb begin
    state_d    = state_q;
    feed_ok_o  = 1'b0;
    feed_err_o = 1'b0;
    if (wr_en_i) begin
      unique case (state_q)
        FS_IDLE: begin
          if (wr_addr_i == REG_CTRL)      state_d = FS_CTRL_WAIT;
          else if (key1_hit)              state_d = FS_KEY1_OK;
          else if (wr_addr_i != REG_LIMIT) feed_err_o = 1'b1;
        end
        FS_CTRL_WAIT: begin
          if (key1_hit) state_d = FS_KEY1_OK;
          else          feed_err_o = 1'b1;
        end
        FS_KEY1_OK: begin
          if (key2_hit) begin
            feed_ok_o = 1'b1;
            state_d   = FS_IDLE;
          end else begin
            feed_err_o = 1'b1;
          end
        end
        default: state_d = FS_IDLE;
      endcase
      if (feed_err_o) state_d = FS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= FS_IDLE;
    else if (flush_i) state_q <= FS_IDLE;
    else              state_q <= state_d;
  end

  assign ctrl_wait_o = (state_q == FS_CTRL_WAIT);
endmodule

// File: rtl/wdt_ctrl_shadow.sv
module wdt_ctrl_shadow
  import wdt_feed_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_CTRL = 8'hE5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              discard_i,
  input  logic              set_tof_i,
  output wdt_ctrl_t         active_o,
  output logic              tof_o
);
  wdt_ctrl_t shadow_q, active_q;
  logic      pend_q, tof_q;
  logic      apply;

  assign apply = commit_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= wdt_ctrl_t'(RST_CTRL);
      pend_q   <= 1'b0;
    end else if (discard_i) begin
      pend_q   <= 1'b0;
    end else if (ctrl_wr_i) begin
      shadow_q <= wdt_ctrl_t'(wr_data_i);
      pend_q   <= 1'b1;
    end else if (commit_i) begin
      pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    active_q <= wdt_ctrl_t'(RST_CTRL);
    else if (apply) active_q <= shadow_q;
  end

  // flag: any watchdog reset sets it; only a committed 0 clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tof_q <= 1'b0;
    else if (set_tof_i)               tof_q <= 1'b1;
    else if (apply && !shadow_q.tof)  tof_q <= 1'b0;
  end

  assign active_o = active_q;
  assign tof_o    = tof_q;
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned PRE_W       = 3,
  parameter int unsigned PRE_BASE    = 5,
  parameter int unsigned SRC_DIV_W   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdclk_i,
  input  logic             clk_sel_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic             dec_tick_o
);
  localparam int unsigned PSC_W = PRE_BASE + (1 << PRE_W) - 1;

  logic [SYNC_STAGES:0]  sync_q;
  logic [SRC_DIV_W-1:0]  div_q;
  logic [PSC_W-1:0]      psc_q, psc_last;
  logic                  osc_rise, pclk_tick, src_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], wdclk_i};
  end
  assign osc_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clear_i) div_q <= '0;
    else if (run_i)   div_q <= div_q + 1'b1;
  end
  assign pclk_tick = run_i && (&div_q);

  assign src_tick = clk_sel_i ? (run_i && osc_rise) : pclk_tick;

  always_comb psc_last = (PSC_W'(1) << (PRE_BASE + 32'(pre_i))) - PSC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       psc_q <= '0;
    else if (clear_i)  psc_q <= '0;
    else if (src_tick) psc_q <= (psc_q == psc_last) ? '0 : psc_q + 1'b1;
  end

  assign dec_tick_o = src_tick && (psc_q == psc_last);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned        CNT_W     = 8,
  parameter logic [CNT_W-1:0]   RST_COUNT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             dec_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;

  assign underflow_o = dec_i && run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= RST_COUNT;
    else if (reload_i)           cnt_q <= limit_i;
    else if (dec_i && run_i)     cnt_q <= (cnt_q == '0) ? limit_i : cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdt_feed_top.sv
module wdt_feed_top
  import wdt_feed_pkg::*;
#(
  parameter int unsigned       PRE_W       = 3,
  parameter int unsigned       PRE_BASE    = 5,
  parameter int unsigned       SRC_DIV_W   = 5,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       RST_CYCLES  = 4,
  parameter logic [DATA_W-1:0] RST_CTRL    = 8'hE5,
  parameter logic [DATA_W-1:0] RST_LIMIT   = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdclk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wdt_rst_o,
  output logic              wdtof_o,
  output logic [DATA_W-1:0] count_o
);
  localparam int unsigned PULSE_W = $clog2(RST_CYCLES + 1);

  logic              feed_ok, feed_err, ctrl_wait;
  logic              underflow, wd_event, dec_tick, restart;
  logic [DATA_W-1:0] limit_q;
  logic [PULSE_W-1:0] pulse_q;
  wdt_ctrl_t         ctrl;

  assign wd_event = feed_err || underflow;
  assign restart  = feed_ok || wd_event;

  wdt_feed_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .flush_i    (underflow),
    .feed_ok_o  (feed_ok),
    .feed_err_o (feed_err),
    .ctrl_wait_o(ctrl_wait)
  );

  wdt_ctrl_shadow #(.RST_CTRL(RST_CTRL)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_wr_i(wr_en_i && (wr_addr_i == REG_CTRL) && !feed_err),
    .wr_data_i(wr_data_i),
    .commit_i (feed_ok),
    .discard_i(wd_event),
    .set_tof_i(wd_event),
    .active_o (ctrl),
    .tof_o    (wdtof_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    limit_q <= RST_LIMIT;
    else if (wr_en_i && (wr_addr_i == REG_LIMIT))   limit_q <= wr_data_i;
  end

  wdt_tick_gen #(
    .PRE_W      (PRE_W),
    .PRE_BASE   (PRE_BASE),
    .SRC_DIV_W  (SRC_DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdclk_i   (wdclk_i),
    .clk_sel_i (ctrl.clk_sel),
    .pre_i     (ctrl.pre),
    .run_i     (ctrl.run),
    .clear_i   (restart),
    .dec_tick_o(dec_tick)
  );

  wdt_down_counter #(.CNT_W(DATA_W), .RST_COUNT(RST_LIMIT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (restart),
    .limit_i    (limit_q),
    .dec_i      (dec_tick),
    .run_i      (ctrl.run),
    .count_o    (count_o),
    .underflow_o(underflow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pulse_q <= '0;
    else if (wd_event)      pulse_q <= PULSE_W'(RST_CYCLES);
    else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
  end

  assign wdt_rst_o = (pulse_q != '0);
endmodule

// File: rtl/wdt_feed_top_chk.sv
module wdt_feed_top_chk
  import wdt_feed_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wdt_rst_o,
  input logic              wdtof_o,
  input logic [DATA_W-1:0] count_o,
  input logic [DATA_W-1:0] limit_q,
  input logic              ctrl_wait
);
  logic [15:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= '0;
    else if (wr_en_i)   hi_run <= '0;
    else if (wdt_rst_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  p_bad_key1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_KEY1 && wr_data_i != FEED_KEY1) |=> wdt_rst_o);

  p_pulse_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (hi_run < 16'(RST_CYCLES)));

  p_ctrl_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_wait && !(wr_addr_i == REG_KEY1 && wr_data_i == FEED_KEY1))
      |=> wdt_rst_o);

  p_tof_on_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> wdtof_o);

  p_tof_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdtof_o) |-> $past(wr_en_i && wr_addr_i == REG_KEY2 && wr_data_i == FEED_KEY2));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      ((count_o == $past(count_o) - 8'd1) || (count_o == $past(limit_q))));
endmodule

bind wdt_feed_top wdt_feed_top_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .wdt_rst_o(wdt_rst_o),
  .wdtof_o  (wdtof_o),
  .count_o  (count_o),
  .limit_q  (limit_q),
  .ctrl_wait(ctrl_wait)
);

// File: tb/wdt_feed_top_test.sv
module wdt_feed_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wdclk_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       wdt_rst_o, wdtof_o;
  logic [7:0] count_o;

  int n_chk = 0;
  int n_bad = 0;

  wdt_feed_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdclk_i(wdclk_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wdt_rst_o(wdt_rst_o), .wdtof_o(wdtof_o), .count_o(count_o)
  );

  always #4 clk_i = ~clk_i;
  always #24 wdclk_i = ~wdclk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic feed();
    bus_wr(2'd2, 8'hA5);
    bus_wr(2'd3, 8'h5A);
  endtask

  task automatic wait_idle();
    while (wdt_rst_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // cycles from the negedge after the feed edge until wdt_rst_o rises
  task automatic wait_rst(input int lim, output int n);
    n = 0;
    while (!wdt_rst_o && n < lim) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check(wdt_rst_o == 1'b0, "R1 rst", int'(wdt_rst_o), 0);
    check(wdtof_o == 1'b0, "R1 tof", int'(wdtof_o), 0);
    check(count_o == 8'hFF, "R1 count", int'(count_o), 255);
    bus_wr(2'd1, 8'h10);
    check(count_o == 8'hFF, "R1 limit no reload", int'(count_o), 255);
  endtask

  task automatic t_valid_feed();
    do_reset();
    bus_wr(2'd1, 8'h10);  // R12 limit at address 1
    feed();
    check(count_o == 8'h10, "R2 reload", int'(count_o), 16);
    check(wdt_rst_o == 1'b0, "R2 no reset", int'(wdt_rst_o), 0);
    bus_wr(2'd1, 8'h33);
    feed();
    check(count_o == 8'h33, "R12 second reload", int'(count_o), 51);
  endtask

  task automatic t_bad_key1();
    int hi;
    do_reset();
    bus_wr(2'd2, 8'h33);
    check(wdt_rst_o == 1'b1, "R3 pulse start", int'(wdt_rst_o), 1);
    check(wdtof_o == 1'b1, "R7 tof on reset", int'(wdtof_o), 1);
    hi = 1;
    while (wdt_rst_o && hi < 20) begin
      @(negedge clk_i);
      if (wdt_rst_o) hi++;
    end
    check(hi == 4, "R3 pulse length", hi, 4);
  endtask

  task automatic t_bad_key2();
    do_reset();
    bus_wr(2'd3, 8'h5A);
    check(wdt_rst_o == 1'b1, "R4 lone key2", int'(wdt_rst_o), 1);
    wait_idle();
    bus_wr(2'd2, 8'hA5);
    bus_wr(2'd3, 8'h00);
    check(wdt_rst_o == 1'b1, "R4 wrong key2", int'(wdt_rst_o), 1);
    wait_idle();
    bus_wr(2'd2, 8'hA5);
    bus_wr(2'd1, 8'h05);
    check(wdt_rst_o == 1'b1, "R4 limit between keys", int'(wdt_rst_o), 1);
  endtask

  task automatic t_ctrl_guard();
    do_reset();
    bus_wr(2'd0, 8'h04);
    bus_wr(2'd1, 8'h07);
    check(wdt_rst_o == 1'b1, "R5 limit after ctrl", int'(wdt_rst_o), 1);
    wait_idle();
    bus_wr(2'd0, 8'h04);
    bus_wr(2'd3, 8'h5A);
    check(wdt_rst_o == 1'b1, "R5 key2 after ctrl", int'(wdt_rst_o), 1);
    wait_idle();
    bus_wr(2'd0, 8'h04);
    feed();
    check(wdt_rst_o == 1'b0, "R5 proper feed after ctrl", int'(wdt_rst_o), 0);
  endtask

  task automatic t_pclk_and_shadow();
    int n;
    do_reset();
    bus_wr(2'd1, 8'd1);
    bus_wr(2'd0, 8'h04);  // pre 0, run, pclk source
    feed();
    wait_rst(3000, n);
    check(n >= 2046 && n <= 2050, "R9 pre0 latency", n, 2048);
    check(wdtof_o == 1'b1, "R7 tof after underflow", int'(wdtof_o), 1);
    check(count_o == 8'd1, "R7 reload on underflow", int'(count_o), 1);
    wait_idle();
    bus_wr(2'd0, 8'h24);  // pre 1, then a failed feed
    bus_wr(2'd2, 8'hA5);
    bus_wr(2'd3, 8'h11);
    wait_idle();
    feed();
    wait_rst(5000, n);
    check(n >= 2046 && n <= 2050, "R6 discarded ctrl", n, 2048);
    wait_idle();
    bus_wr(2'd0, 8'h24);
    feed();
    wait_rst(6000, n);
    check(n >= 4094 && n <= 4098, "R9 pre1 latency", n, 4096);
  endtask

  task automatic t_osc_source();
    int n;
    do_reset();
    bus_wr(2'd1, 8'd1);
    bus_wr(2'd0, 8'h05);  // pre 0, run, oscillator source
    feed();
    wait_rst(3000, n);
    check(n >= 376 && n <= 398, "R10 osc latency", n, 384);
  endtask

  task automatic t_stopped();
    int seen;
    do_reset();
    bus_wr(2'd1, 8'd3);
    bus_wr(2'd0, 8'h00);
    feed();
    seen = 0;
    repeat (6000) begin
      @(negedge clk_i);
      if (wdt_rst_o) seen++;
    end
    check(seen == 0, "R8 no timeout when stopped", seen, 0);
    check(count_o == 8'd3, "R8 count held", int'(count_o), 3);
  endtask

  task automatic t_tof_clear();
    do_reset();
    bus_wr(2'd2, 8'h00);
    wait_idle();
    check(wdtof_o == 1'b1, "R11 set", int'(wdtof_o), 1);
    bus_wr(2'd0, 8'h06);
    feed();
    check(wdtof_o == 1'b1, "R11 commit with bit1=1", int'(wdtof_o), 1);
    bus_wr(2'd1, 8'h00);
    check(wdtof_o == 1'b1, "R11 limit write", int'(wdtof_o), 1);
    bus_wr(2'd0, 8'h04);
    feed();
    check(wdtof_o == 1'b0, "R11 commit with bit1=0", int'(wdtof_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_valid_feed();
    t_bad_key1();
    t_bad_key2();
    t_ctrl_guard();
    t_pclk_and_shadow();
    t_osc_source();
    t_stopped();
    t_tof_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule